// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block passes a free-running source clock to an output and removes it on request to save power. The stop request is active low and arrives with no timing relation to the source clock. It is resynchronized on the source clock before it reaches the gate. The gate enable is a register that updates only on the falling edge of the source, and the output is the source ANDed with that enable. The output therefore parks low when stopped and resumes with a complete first high phase. No runt pulse can appear.

Two parameters size the block. `SYNC_STAGES` sets the depth of the request synchronizer, and with it the stop and start latency. `MIN_ON` sets the minimum number of cycles the clock stays enabled after each restart. A fast processor-clock group uses `SYNC_STAGES=2` and `MIN_ON=100`. A slower bus-clock group uses `SYNC_STAGES=1` and `MIN_ON=10`. A stop request that arrives inside the minimum window is held pending and takes effect when the window closes. A status output reports when the gate is closed. Other clocks on the chip are not touched by this block.

Top module: `clk_stop_gate`

## Requirements
- R1: A change of `stop_req_n` reaches the gate control only after passing through `SYNC_STAGES` flops clocked on the rising edge of `clk_in`. It never acts earlier than that.
- R2: Once the minimum window is satisfied, `stopped_o` rises on the falling edge of `clk_in` that follows the (`SYNC_STAGES`+1)-th rising edge after `stop_req_n` falls. `clk_out` produces exactly `SYNC_STAGES`+1 rising edges in that span, which is 3 (fewer than 4) with the defaults.
- R3: While `stopped_o` is 1, `clk_out` is held at 0 and shows no rising edge.
- R4: Every high phase of `clk_out` lasts exactly one full high phase of `clk_in`, including the first one after a restart.
- R5: After `stop_req_n` rises on a stopped clock, `stopped_o` falls after `SYNC_STAGES`+1 rising edges of `clk_in`. The very next rising edge of `clk_in` is the first rising edge of `clk_out`.
- R6: Each enabled interval contains at least `MIN_ON`+1 rising edges of `clk_out`. When a stop is requested continuously from the restart onward, the interval contains exactly `MIN_ON`+1.
- R7: A stop request that is asserted and withdrawn inside the minimum window is not lost. The gate closes when the window ends and, since no request remains, reopens after exactly one `clk_in` cycle.
- R8: While `rst_n` is 0, the gate is open, `stopped_o` is 0 and the synchronizer holds the not-stopped level. The minimum window counts as already satisfied, so a stop right after reset follows R2.
- R9: `stopped_o` is 1 exactly while the gate enable is off. It changes only on a falling edge of `clk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running source clock; also clocks the synchronizer and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| clk_out | output | 1 | Gated clock output |
| stopped_o | output | 1 | 1 while the gated clock is parked low |

## Verification
On every source cycle, the assertions check four things. The control never closes the gate before the minimum window completes. Each open and close follows a synchronized request level or a pending request. The counter restarts with each reopening. The status flag and the output never show a high output while stopped. Only the bench scenarios can show the end-to-end timing: the exact stop and start latencies counted in edges, the width of every output high phase, the exact edge count of a minimum window, and the single-cycle gap left by a withdrawn pending request. Random request patterns of mixed duration exercise these paths alongside the directed cases.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_ON      = 100
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic stop_req_n,
  output logic clk_out,
  output logic stopped_o
);
  localparam int CW = $clog2(MIN_ON + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(MIN_ON);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_req;
  logic                   en_q;
  logic                   pend;
  logic [CW-1:0]          cnt;

  wire req_stop = ~sync_q[SYNC_STAGES-1];
  wire cnt_done = (cnt == CNT_FULL);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= SYNC_STAGES'({sync_q, stop_req_n});
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      en_req <= 1'b1;
      cnt    <= CNT_FULL;
      pend   <= 1'b0;
    end else if (en_req) begin
      if (cnt_done && (req_stop || pend)) begin
        en_req <= 1'b0;
        pend   <= 1'b0;
      end else if (!cnt_done) begin
        cnt <= cnt + 1'b1;
        if (req_stop) pend <= 1'b1;
      end
    end else if (!req_stop) begin
      en_req <= 1'b1;
      cnt    <= '0;
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_req;
  end

  assign clk_out   = clk_in & en_q;
  assign stopped_o = ~en_q;

  // R6
  close_after_window_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $fell(en_req) |-> $past(cnt) == CNT_FULL);

  // R1
  close_needs_request_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $fell(en_req) |-> ($past(sync_q[SYNC_STAGES-1]) == 1'b0 || $past(pend)));

  // R5
  open_needs_release_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(en_req) |-> $past(sync_q[SYNC_STAGES-1]) == 1'b1);

  // R6
  window_restart_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(en_req) |-> cnt == '0);

  // R3
  parked_low_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    stopped_o |-> !clk_out);
endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  localparam int SYNC   = 2;
  localparam int MIN_ON = 100;
  localparam int LAT    = SYNC + 1;

  logic clk_in = 1'b0;
  logic rst_n  = 1'b0;
  logic stop_req_n = 1'b1;
  logic clk_out, stopped_o;

  int compared = 0;
  int mismatched = 0;
  int in_edges = 0;
  int out_edges = 0;
  time t_rise = 0;

  clk_stop_gate #(.SYNC_STAGES(SYNC), .MIN_ON(MIN_ON)) u_dut (
    .clk_in(clk_in), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .clk_out(clk_out), .stopped_o(stopped_o));

  always #10 clk_in = ~clk_in;

  always @(posedge clk_in) in_edges++;
  always @(posedge clk_out) begin out_edges++; t_rise = $time; end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R4: every high phase equals the source high phase (10 ns)
  always @(negedge clk_out) if (rst_n) chk("R4 high width", int'($time - t_rise), 10);

  // R3: sampled while clk_in is high
  always @(posedge clk_in) begin
    #2;
    if (rst_n && stopped_o) chk("R3 parked low", int'(clk_out), 0);
  end

  task automatic tick();
    @(negedge clk_in); #2;
  endtask

  task automatic wait_stopped(input logic lvl);
    for (int i = 0; i < 400; i++) begin
      if (stopped_o === lvl) break;
      tick();
    end
  endtask

  function automatic int exp_stopped(input logic lvl, input int hold);
    if (!lvl && hold >= MIN_ON + 8) return 1;
    if (lvl && hold >= LAT + 3) return 0;
    return -1;
  endfunction

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int e_in, e_out, ex;
    logic lvl;
    void'($urandom(32'd2024));
    tick(); tick();
    // R8: reset state
    chk("R8 stopped in reset", int'(stopped_o), 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R8 running after reset", int'(stopped_o), 0);

    // R2 + R8 + R1: stop right after reset
    e_in = in_edges; e_out = out_edges;
    stop_req_n = 1'b0;
    tick();
    chk("R1 no early stop", int'(stopped_o), 0);
    wait_stopped(1'b1);
    chk("R2 off latency src edges", in_edges - e_in, LAT);
    chk("R2 off latency out edges", out_edges - e_out, LAT);

    // R3: held off
    e_out = out_edges;
    repeat (20) tick();
    chk("R3 no edges while stopped", out_edges - e_out, 0);
    chk("R9 status held", int'(stopped_o), 1);

    // R5: restart latency
    e_in = in_edges; e_out = out_edges;
    stop_req_n = 1'b1;
    wait_stopped(1'b0);
    chk("R5 on latency src edges", in_edges - e_in, LAT);
    chk("R5 no output edge yet", out_edges - e_out, 0);
    tick();
    chk("R5 first output edge", out_edges - e_out, 1);

    // R6: continuous request right after restart
    stop_req_n = 1'b0;
    wait_stopped(1'b1);
    stop_req_n = 1'b1;
    wait_stopped(1'b0);
    e_out = out_edges;
    stop_req_n = 1'b0;
    wait_stopped(1'b1);
    chk("R6 min window edges", out_edges - e_out, MIN_ON + 1);

    // R7: short request inside the window
    stop_req_n = 1'b1;
    wait_stopped(1'b0);
    e_out = out_edges;
    stop_req_n = 1'b0;
    repeat (8) tick();
    stop_req_n = 1'b1;
    wait_stopped(1'b1);
    chk("R7 pending stop applied", out_edges - e_out, MIN_ON + 1);
    e_in = in_edges;
    wait_stopped(1'b0);
    chk("R7 single cycle gap", in_edges - e_in, 1);
    repeat (LAT + 2) tick();
    chk("R7 stays running", int'(stopped_o), 0);

    // random request levels and durations
    for (int k = 0; k < 40; k++) begin
      int hold;
      lvl  = 1'($urandom_range(0, 1));
      hold = int'($urandom_range(1, MIN_ON + 30));
      stop_req_n = lvl;
      repeat (hold) tick();
      ex = exp_stopped(lvl, hold);
      if (ex >= 0) chk(lvl ? "R5 random running" : "R2 random stopped", int'(stopped_o), ex);
    end

    stop_req_n = 1'b1;
    repeat (10) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule